// File: doc/BRIEF.md
# Burst Address Counter

This block is the address register of one memory port, built so that it can also act as a loadable up-counter for burst traffic. On every rising clock edge it samples an external address and three active-low controls: a counter clear, an address strobe and a count enable. From these it works out the address that the memory access of the new cycle uses. That address is either zero, the external address, the previous address plus one, or the previous address unchanged.

The chosen address is held in the output register. The access that begins at the edge therefore uses it directly, with no dead cycle. A clear or a load takes effect in the same access that requests it. The block also reports which of the four operations produced the current address, so that a neighbour can tell a fresh load from a burst step. A synchronous active-high system reset sets the power-up state. The controls do not depend on chip enables, byte selects or the read/write direction, so no such inputs exist here.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_addr` becomes 0 and `acc_op` becomes 3 (hold) after that edge.
- R2: When `clr_n` is low at an edge, `acc_addr` is 0 after that edge, and `acc_op` is 0 (clear).
- R3: A low `clr_n` wins over a low `strobe_n` and a low `step_n` in the same cycle; the external address is not used.
- R4: When `clr_n` is high and `strobe_n` is low at an edge, `acc_addr` equals the sampled `ext_addr` after that edge, and `acc_op` is 1 (load).
- R5: A load wins over a low `step_n` in the same cycle: the loaded address is used as it is, not plus one.
- R6: When `clr_n` and `strobe_n` are high and `step_n` is low at an edge, `acc_addr` becomes its previous value plus one, and `acc_op` is 2 (step).
- R7: A step from the all-ones address gives address 0 (modulo 2^ADDR_W wrap).
- R8: When all three controls are high at an edge, `acc_addr` keeps its previous value whatever `ext_addr` carries, and `acc_op` is 3 (hold).
- R9: A clear or load cycle is followed directly by a usable step: the address after clear-then-step is 1, and after load A then step it is A+1, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high system reset |
| ext_addr | input | ADDR_W | External address, used on a load |
| strobe_n | input | 1 | Active-low address strobe (load) |
| step_n | input | 1 | Active-low count enable (increment) |
| clr_n | input | 1 | Active-low counter clear |
| acc_addr | output | ADDR_W | Address used by the access of the current cycle |
| acc_op | output | 2 | Operation that produced acc_addr: 0 clear, 1 load, 2 step, 3 hold |

## Verification
Each result is due after exactly one rising edge: the controls sampled at edge k set `acc_addr` and `acc_op` in the cycle that follows edge k. The bench drives inputs on the falling edge and pushes the expected pair into a queue. A monitor then compares the output a quarter period after the next rising edge, so each queued item lines up with the single register between input and output. The stimulus includes the priority collisions, wrap-around at all ones, back-to-back clear and load followed by a step, and long holds while the external address changes.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_HOLD  = 2'd3
  } bac_op_e;

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_addr_pkg::*;
(
  input  logic    clr_n,
  input  logic    strobe_n,
  input  logic    step_n,
  output bac_op_e op
);

  // Fixed priority: clear, then load, then step, otherwise hold.
  always_comb begin
    if (!clr_n)         op = OP_CLEAR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!step_n)   op = OP_STEP;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  bac_op_e           op,
  input  logic [ADDR_W-1:0] ext,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] inc;

  // Modulo increment: all ones rolls over to zero.
  assign inc = cur + ONE;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = inc;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        acc_op
);

  bac_op_e           op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  bac_op_e           op_q;

  burst_op_decode u_dec (
    .clr_n    (clr_n),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .op       (op_d)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .op  (op_d),
    .ext (ext_addr),
    .cur (addr_q),
    .nxt (addr_d)
  );

  // The register is both the counter state and the access address,
  // so a clear or load reaches the access of the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      op_q   <= OP_HOLD;
    end else begin
      addr_q <= addr_d;
      op_q   <= op_d;
    end
  end

  assign acc_addr = addr_q;
  assign acc_op   = op_q;

endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_n,
  input logic              step_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_op
);

  p_sys_reset_r1: assert property (@(posedge clk)
    rst |=> (acc_addr == '0 && acc_op == 2'd3));

  // R2 and R3: clear dominates every other control
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (acc_addr == '0 && acc_op == 2'd0));

  // R4 and R5: load dominates step
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe_n) |=> (acc_addr == $past(ext_addr) && acc_op == 2'd1));

  // R6 and R7: modulo increment
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && !step_n) |=>
      (acc_addr == ADDR_W'($past(acc_addr) + 1'b1) && acc_op == 2'd2));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && step_n) |=> ($stable(acc_addr) && acc_op == 2'd3));

endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ext_addr (ext_addr),
  .strobe_n (strobe_n),
  .step_n   (step_n),
  .clr_n    (clr_n),
  .acc_addr (acc_addr),
  .acc_op   (acc_op)
);

// File: tb/sim_burst_addr_ctr.sv
module sim_burst_addr_ctr;

  localparam int CLK_PER = 10;
  localparam int AW      = 16;
  localparam int WDOG    = 20000;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    op;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          step_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_op;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [AW-1:0] model = '0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW)) u0 (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .acc_addr (acc_addr),
    .acc_op   (acc_op)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: applies one cycle of controls at the falling edge and queues the result.
  task automatic drive(input logic c_n, input logic s_n, input logic e_n,
                       input logic [AW-1:0] a, input string tag);
    exp_t it;
    @(negedge clk);
    clr_n = c_n; strobe_n = s_n; step_n = e_n; ext_addr = a;
    if (!c_n)      begin model = '0;               it.op = 2'd0; end
    else if (!s_n) begin model = a;                it.op = 2'd1; end
    else if (!e_n) begin model = AW'(model + 1'b1); it.op = 2'd2; end
    else           begin                           it.op = 2'd3; end
    it.addr = model;
    it.tag  = tag;
    q.push_back(it);
  endtask

  // Monitor: one register between input and output, so compare after the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PER/4);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (acc_addr !== it.addr || acc_op !== it.op) begin
          errors++;
          $display("FAIL %s: actual addr=%h op=%0d expected addr=%h op=%0d",
                   it.tag, acc_addr, acc_op, it.addr, it.op);
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual cycles %0d expected fewer", WDOG);
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    repeat (3) @(posedge clk);
    #(CLK_PER/4);
    checks++;
    if (acc_addr !== '0 || acc_op !== 2'd3) begin
      errors++;
      $display("FAIL R1: actual addr=%h op=%0d expected addr=0000 op=3", acc_addr, acc_op);
    end
    @(negedge clk);
    rst = 1'b0;
    model = '0;

    drive(1, 0, 1, 16'h1234, "R4");
    drive(1, 1, 0, 16'h0000, "R6");
    drive(1, 1, 0, 16'hFFFF, "R6");
    drive(1, 1, 1, 16'hAAAA, "R8");
    drive(1, 1, 1, 16'h5555, "R8");
    drive(0, 1, 1, 16'h7777, "R2");
    drive(1, 1, 0, 16'h7777, "R9");   // clear then step gives 1
    drive(1, 0, 1, 16'h0042, "R4");
    drive(0, 0, 0, 16'hBEEF, "R3");   // clear beats load and step
    drive(1, 0, 0, 16'h0100, "R5");   // load beats step, no plus one
    drive(1, 1, 0, 16'h9999, "R9");   // load then step gives A+1
    drive(1, 0, 1, 16'hFFFE, "R4");
    drive(1, 1, 0, 16'h0000, "R7");
    drive(1, 1, 0, 16'h0000, "R7");   // FFFF wraps to 0000
    drive(1, 1, 0, 16'h0000, "R7");
    drive(1, 0, 1, 16'hFFFF, "R4");
    drive(1, 1, 1, 16'h0000, "R8");
    drive(1, 1, 0, 16'h0000, "R7");
    drive(0, 1, 0, 16'h1111, "R2");

    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      string tg;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!lfsr[0] && !lfsr[1]) tg = "R2";
      else if (!lfsr[1] && lfsr[0] && !lfsr[2]) tg = "R4";
      else if (lfsr[1] && lfsr[0] && !lfsr[2]) tg = "R4";
      else if (!lfsr[3]) tg = "R6";
      else tg = "R8";
      drive(lfsr[0] | lfsr[1], lfsr[2] | ~lfsr[4], lfsr[3], {lfsr[7:0], lfsr[15:8]}, tg);
    end

    @(negedge clk);
    clr_n = 1; strobe_n = 1; step_n = 1;
    repeat (3) @(posedge clk);
    #(CLK_PER/2);
    done = 1'b1;
    summary();
  end

endmodule